// File: doc/BRIEF.md
# Axon Connection Matrix with Bus Configuration Port

This block stores, for every input axon of a spiking neuron array, a 32-bit connection row. Bit j of a row states whether that axon drives neuron j. Software fills the rows through a 32-bit Wishbone classic slave port. Each write can update any subset of the four byte lanes, and every word can be read back.

On a second, independent port the neuron array presents the index of an incoming axon together with a valid strobe. One cycle later the block returns that axon's row, and all 32 neurons receive their connection bit in parallel.

The block also classifies every bus address into one of four regions. The neighbouring neuron-parameter and spike-output blocks use this classification to select themselves, and it is brought out on a port. The block acknowledges every bus request in the cycle after the request, whether or not the address is mapped.

Top module: `conn_matrix_wb`

## Requirements
- R1: While `rst_n` is low, and after it rises, `wb_ack_o` and `row_valid_o` are low, `row_o` is zero, and every connection row reads as zero.
- R2: `region_o` is a combinational function of `wb_adr_i` with these codes:
  - 2'b01 for 0x30000000–0x30003FFF
  - 2'b10 for 0x30004000–0x300040FF
  - 2'b11 for 0x30008000–0x30008003
  - 2'b00 for any other address
- R3: The row of axon k (0..255) is at byte address 0x30000000 + 4*k. A full-word write to that address followed by a read of it returns the written word.
- R4: When `wb_cyc_i` and `wb_stb_i` are both high and `wb_ack_o` is low, `wb_ack_o` is high in the next cycle for exactly one cycle. Read data is valid in that same cycle. A master that keeps its request up is acknowledged on alternate cycles. `wb_stb_i` without `wb_cyc_i` is never acknowledged.
- R5: On a write, `wb_sel_i[b]` high updates bits 8b+7..8b of the addressed row. Bytes whose select bit is low keep their previous value.
- R6: Addresses 0x30000400–0x30003FFF read as zero, and writes to them change no row.
- R7: Requests to the parameter region, the spike region or an unmapped address are acknowledged like matrix requests. They read as zero, and writes to them change no row.
- R8: `row_valid_o` equals `axon_valid_i` of the previous cycle. While it is high, `row_o` equals the current content of the row whose index was on `axon_idx_i` in that previous cycle, with bit j going to neuron j. While it is low, `row_o` is zero.
- R9: A valid strobe held high with a new index every cycle yields the matching row on every following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | Write enable |
| wb_sel_i | input | 4 | Byte-lane selects |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_ack_o | output | 1 | One-cycle acknowledge |
| wb_dat_o | output | 32 | Read data, valid with acknowledge |
| region_o | output | 2 | Region code of current address |
| axon_valid_i | input | 1 | Axon index valid |
| axon_idx_i | input | 8 | Index of incoming axon |
| row_valid_o | output | 1 | Connection row valid |
| row_o | output | 32 | Connection row, bit j to neuron j |

## Verification
The bench probes the region edges one byte inside and outside each window. An off-by-one mask would leak parameter addresses into the matrix or would drop the last spike byte. Writes into the hole above the last row, and to unmapped addresses whose low bits equal a real row offset, catch a decoder that indexes on the low address bits alone: such a design overwrites rows 0 or 3. Partial byte-lane writes, including an all-zero select, expose a store that writes whole words. A continuously held request shows whether the acknowledge is re-armed without a gap. Back-to-back fan-out indices catch an index register that lags or holds.

// File: rtl/conn_matrix_pkg.sv
package conn_matrix_pkg;
  typedef enum logic [1:0] {
    RG_NONE   = 2'b00,
    RG_MATRIX = 2'b01,
    RG_PARAM  = 2'b10,
    RG_SPIKE  = 2'b11
  } region_e;
endpackage

// File: rtl/cm_region_decode.sv
module cm_region_decode
  import conn_matrix_pkg::*;
#(
  parameter int          AW             = 32,
  parameter int          IDX_W          = 8,
  parameter logic [31:0] MATRIX_BASE    = 32'h3000_0000,
  parameter int          MATRIX_SPAN_LG = 14,
  parameter logic [31:0] PARAM_BASE     = 32'h3000_4000,
  parameter int          PARAM_SPAN_LG  = 8,
  parameter logic [31:0] SPIKE_BASE     = 32'h3000_8000,
  parameter int          SPIKE_SPAN_LG  = 2
) (
  input  logic [AW-1:0]    adr,
  output region_e          region,
  output logic             row_hit,
  output logic [IDX_W-1:0] row_idx
);
  localparam logic [AW-1:0] M_MASK = AW'((64'd1 << MATRIX_SPAN_LG) - 64'd1);
  localparam logic [AW-1:0] P_MASK = AW'((64'd1 << PARAM_SPAN_LG) - 64'd1);
  localparam logic [AW-1:0] S_MASK = AW'((64'd1 << SPIKE_SPAN_LG) - 64'd1);
  localparam logic [AW-1:0] ROWS_MASK = AW'((64'd1 << (IDX_W + 2)) - 64'd1);
  localparam logic [AW-1:0] HOLE_MASK = M_MASK & ~ROWS_MASK;

  logic in_m, in_p, in_s;

  always_comb begin
    in_m = ((adr ^ MATRIX_BASE[AW-1:0]) & ~M_MASK) == '0;
    in_p = ((adr ^ PARAM_BASE[AW-1:0]) & ~P_MASK) == '0;
    in_s = ((adr ^ SPIKE_BASE[AW-1:0]) & ~S_MASK) == '0;
    if (in_m)      region = RG_MATRIX;
    else if (in_p) region = RG_PARAM;
    else if (in_s) region = RG_SPIKE;
    else           region = RG_NONE;
    row_hit = in_m && ((adr & HOLE_MASK) == '0);
    row_idx = adr[IDX_W+1:2];
  end
endmodule

// File: rtl/cm_row_store.sv
module cm_row_store #(
  parameter int N_ROWS = 256,
  parameter int DW     = 32,
  localparam int IDX_W = $clog2(N_ROWS),
  localparam int NB    = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [NB-1:0]    wr_be,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [DW-1:0]    rd_data_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [DW-1:0]    rd_data_b
);
  logic [DW-1:0] mem_q [N_ROWS];
  logic [DW-1:0] mem_d [N_ROWS];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    for (genvar b = 0; b < NB; b++) begin : g_lane
      logic lane_en;
      always_comb begin
        lane_en = wr_en && (wr_idx == IDX_W'(r)) && wr_be[b];
        mem_d[r][8*b +: 8] = lane_en ? wr_data[8*b +: 8] : mem_q[r][8*b +: 8];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[r] <= '0;
      else        mem_q[r] <= mem_d[r];
    end
  end

  assign rd_data_a = mem_q[rd_idx_a];
  assign rd_data_b = mem_q[rd_idx_b];
endmodule

// File: rtl/cm_bus_port.sv
module cm_bus_port #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc,
  input  logic          stb,
  input  logic          we,
  input  logic          row_hit,
  input  logic [DW-1:0] rd_row,
  output logic          wr_en,
  output logic          ack,
  output logic [DW-1:0] dat
);
  logic          ack_q, ack_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          req;

  always_comb begin
    req   = cyc && stb && !ack_q;
    ack_d = req;
    dat_d = (req && !we && row_hit) ? rd_row : '0;
    wr_en = req && we && row_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= ack_d;
      dat_q <= dat_d;
    end
  end

  assign ack = ack_q;
  assign dat = dat_q;
endmodule

// File: rtl/cm_fanout_port.sv
module cm_fanout_port #(
  parameter int DW    = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [DW-1:0]    rd_row,
  output logic             vld_o,
  output logic [DW-1:0]    row_o
);
  logic             vld_q, vld_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    vld_d = vld_i;
    idx_d = vld_i ? idx_i : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= vld_d;
      idx_q <= idx_d;
    end
  end

  assign rd_idx = idx_q;
  assign vld_o  = vld_q;
  assign row_o  = vld_q ? rd_row : '0;
endmodule

// File: rtl/conn_matrix_wb.sv
module conn_matrix_wb
  import conn_matrix_pkg::*;
#(
  parameter int          N_AXON      = 256,
  parameter int          DW          = 32,
  parameter int          AW          = 32,
  parameter logic [31:0] MATRIX_BASE = 32'h3000_0000,
  parameter logic [31:0] PARAM_BASE  = 32'h3000_4000,
  parameter logic [31:0] SPIKE_BASE  = 32'h3000_8000,
  localparam int IDX_W = $clog2(N_AXON),
  localparam int NB    = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [NB-1:0]    wb_sel_i,
  input  logic [AW-1:0]    wb_adr_i,
  input  logic [DW-1:0]    wb_dat_i,
  output logic             wb_ack_o,
  output logic [DW-1:0]    wb_dat_o,
  output logic [1:0]       region_o,
  input  logic             axon_valid_i,
  input  logic [IDX_W-1:0] axon_idx_i,
  output logic             row_valid_o,
  output logic [DW-1:0]    row_o
);
  region_e          region;
  logic             row_hit, wr_en;
  logic [IDX_W-1:0] bus_idx, fan_idx;
  logic [DW-1:0]    bus_row, fan_row;

  cm_region_decode #(
    .AW(AW), .IDX_W(IDX_W),
    .MATRIX_BASE(MATRIX_BASE), .MATRIX_SPAN_LG(14),
    .PARAM_BASE(PARAM_BASE),   .PARAM_SPAN_LG(8),
    .SPIKE_BASE(SPIKE_BASE),   .SPIKE_SPAN_LG(2)
  ) u_dec (
    .adr(wb_adr_i), .region(region), .row_hit(row_hit), .row_idx(bus_idx)
  );

  cm_bus_port #(.DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
    .row_hit(row_hit), .rd_row(bus_row), .wr_en(wr_en),
    .ack(wb_ack_o), .dat(wb_dat_o)
  );

  cm_row_store #(.N_ROWS(N_AXON), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(bus_idx),
    .wr_be(wb_sel_i), .wr_data(wb_dat_i),
    .rd_idx_a(bus_idx), .rd_data_a(bus_row),
    .rd_idx_b(fan_idx), .rd_data_b(fan_row)
  );

  cm_fanout_port #(.DW(DW), .IDX_W(IDX_W)) u_fan (
    .clk(clk), .rst_n(rst_n), .vld_i(axon_valid_i), .idx_i(axon_idx_i),
    .rd_idx(fan_idx), .rd_row(fan_row), .vld_o(row_valid_o), .row_o(row_o)
  );

  assign region_o = region;
endmodule

// File: rtl/conn_matrix_wb_chk.sv
module conn_matrix_wb_chk #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wb_cyc_i,
  input logic             wb_stb_i,
  input logic             wb_ack_o,
  input logic [DW-1:0]    wb_dat_o,
  input logic [1:0]       region_o,
  input logic             axon_valid_i,
  input logic             row_valid_o,
  input logic [DW-1:0]    row_o
);
  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |=> !wb_ack_o);
  a_r4_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);
  a_r4_no_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_cyc_i && wb_stb_i) |=> !wb_ack_o);
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ack_o && region_o != 2'b01) |-> wb_dat_o == '0);
  a_r8_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
    axon_valid_i |=> row_valid_o);
  a_r8_invalid_lag: assert property (@(posedge clk) disable iff (!rst_n)
    !axon_valid_i |=> !row_valid_o);
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !row_valid_o |-> row_o == '0);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!wb_ack_o && !row_valid_o));
endmodule

bind conn_matrix_wb conn_matrix_wb_chk #(.DW(DW), .AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
  .wb_ack_o(wb_ack_o), .wb_dat_o(wb_dat_o), .region_o(region_o),
  .axon_valid_i(axon_valid_i), .row_valid_o(row_valid_o), .row_o(row_o)
);

// File: tb/conn_matrix_wb_test.sv
module conn_matrix_wb_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc, stb, we;
  logic [3:0]  sel;
  logic [31:0] adr, wdat;
  logic        ack;
  logic [31:0] rdat;
  logic [1:0]  region;
  logic        avld;
  logic [7:0]  aidx;
  logic        rvld;
  logic [31:0] row;

  logic [31:0] model [256];
  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  conn_matrix_wb uut (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_sel_i(sel), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_ack_o(ack),
    .wb_dat_o(rdat), .region_o(region), .axon_valid_i(avld),
    .axon_idx_i(aidx), .row_valid_o(rvld), .row_o(row)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      finish_run();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus transfer; returns read data sampled with the acknowledge
  task automatic xfer(input logic w, input logic [31:0] a, input logic [3:0] s,
                      input logic [31:0] d, output logic [31:0] q, input string req);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d;
    @(negedge clk);
    chk({req, " ack"}, 32'(ack), 32'd1);
    q = rdat;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    chk({req, " ack drop"}, 32'(ack), 32'd0);
  endtask

  task automatic wr(input logic [31:0] a, input logic [3:0] s, input logic [31:0] d, input string req);
    logic [31:0] q;
    xfer(1'b1, a, s, d, q, req);
  endtask

  task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string req);
    logic [31:0] q;
    xfer(1'b0, a, 4'hF, 32'h0, q, req);
    chk(req, q, exp);
  endtask

  task automatic fan_chk(input logic [7:0] k, input string req);
    @(negedge clk);
    avld = 1; aidx = k;
    @(negedge clk);
    avld = 0;
    chk({req, " valid"}, 32'(rvld), 32'd1);
    chk(req, row, model[k]);
    @(negedge clk);
    chk({req, " valid drop"}, 32'(rvld), 32'd0);
    chk({req, " idle zero"}, row, 32'h0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 ack in reset", 32'(ack), 32'd0);
    chk("R1 row_valid in reset", 32'(rvld), 32'd0);
    rst_n = 1;
    for (int k = 0; k < 256; k++) model[k] = 32'h0;
    rd_chk(32'h3000_0000, 32'h0, "R1 row0 cleared");
    rd_chk(32'h3000_03FC, 32'h0, "R1 row255 cleared");
    fan_chk(8'd77, "R1 fanout cleared");
  endtask

  task automatic t_decode();
    logic [31:0] a [9];
    logic [1:0]  e [9];
    a = '{32'h3000_0000, 32'h3000_3FFF, 32'h3000_4000, 32'h3000_40FF, 32'h3000_4100,
          32'h3000_8000, 32'h3000_8003, 32'h3000_8004, 32'h2FFF_FFFC};
    e = '{2'b01, 2'b01, 2'b10, 2'b10, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00};
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      adr = a[i];
      #1 chk($sformatf("R2 region of %h", a[i]), 32'(region), 32'(e[i]));
    end
  endtask

  task automatic t_word_rw();
    for (int k = 0; k < 256; k += 17) begin
      model[k] = (k * 32'h0101_0101) ^ 32'h8000_0001;
      wr(32'h3000_0000 + 32'(4 * k), 4'hF, model[k], "R3 write");
    end
    model[255] = 32'hC3A5_5A3C;
    wr(32'h3000_03FC, 4'hF, model[255], "R3 write last");
    rd_chk(32'h3000_0000 + 32'(4 * 34), model[34], "R3 readback row34");
    rd_chk(32'h3000_03FC, model[255], "R3 readback row255");
    rd_chk(32'h3000_0000, model[0], "R3 readback row0");
  endtask

  task automatic t_byte_lanes();
    model[5] = 32'hFFFF_FFFF;
    wr(32'h3000_0014, 4'hF, 32'hFFFF_FFFF, "R5 fill");
    wr(32'h3000_0014, 4'b0101, 32'h1234_5678, "R5 lanes 0,2");
    rd_chk(32'h3000_0014, 32'hFF34_FF78, "R5 lanes 0,2");
    wr(32'h3000_0014, 4'b1000, 32'hAB00_0000, "R5 lane 3");
    rd_chk(32'h3000_0014, 32'hAB34_FF78, "R5 lane 3");
    wr(32'h3000_0014, 4'b0000, 32'h0000_0000, "R5 no lanes");
    rd_chk(32'h3000_0014, 32'hAB34_FF78, "R5 no lanes");
    model[5] = 32'hAB34_FF78;
  endtask

  task automatic t_hole();
    wr(32'h3000_0400, 4'hF, 32'hDEAD_BEEF, "R6 hole write");
    wr(32'h3000_3FFC, 4'hF, 32'hFACE_0FF0, "R6 hole top write");
    rd_chk(32'h3000_0400, 32'h0, "R6 hole reads zero");
    rd_chk(32'h3000_3FFC, 32'h0, "R6 hole top reads zero");
    rd_chk(32'h3000_0000, model[0], "R6 row0 untouched");
    rd_chk(32'h3000_03FC, model[255], "R6 row255 untouched");
  endtask

  task automatic t_other_regions();
    wr(32'h3000_4000, 4'hF, 32'h55AA_55AA, "R7 param write");
    rd_chk(32'h3000_4000, 32'h0, "R7 param reads zero");
    wr(32'h3000_8000, 4'hF, 32'h0F0F_0F0F, "R7 spike write");
    rd_chk(32'h3000_8000, 32'h0, "R7 spike reads zero");
    wr(32'h2000_000C, 4'hF, 32'h7777_7777, "R7 unmapped write");
    rd_chk(32'h2000_000C, 32'h0, "R7 unmapped reads zero");
    rd_chk(32'h3000_000C, model[3], "R7 row3 untouched");
    rd_chk(32'h3000_0000, model[0], "R7 row0 untouched");
  endtask

  task automatic t_ack_timing();
    @(negedge clk);
    cyc = 0; stb = 1; we = 0; adr = 32'h3000_0000;
    @(negedge clk);
    chk("R4 stb without cyc", 32'(ack), 32'd0);
    cyc = 1;
    @(negedge clk);
    chk("R4 held req cycle1", 32'(ack), 32'd1);
    @(negedge clk);
    chk("R4 held req cycle2", 32'(ack), 32'd0);
    @(negedge clk);
    chk("R4 held req cycle3", 32'(ack), 32'd1);
    cyc = 0; stb = 0;
    @(negedge clk);
    chk("R4 released", 32'(ack), 32'd0);
  endtask

  task automatic t_fanout();
    model[9] = 32'h0000_0008;
    wr(32'h3000_0024, 4'hF, model[9], "R8 setup");
    fan_chk(8'd9, "R8 bit3 to neuron3");
    fan_chk(8'd255, "R8 last axon");
    fan_chk(8'd0, "R8 first axon");
    fan_chk(8'd5, "R8 lane-written row");
  endtask

  task automatic t_stream();
    @(negedge clk);
    avld = 1; aidx = 8'd17;
    @(negedge clk);
    aidx = 8'd34;
    chk("R9 stream 17", row, model[17]);
    @(negedge clk);
    aidx = 8'd255;
    chk("R9 stream 34", row, model[34]);
    @(negedge clk);
    avld = 0;
    chk("R9 stream 255", row, model[255]);
    @(negedge clk);
    chk("R9 stream end", 32'(rvld), 32'd0);
  endtask

  task automatic t_reset_midrun();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 256; k++) model[k] = 32'h0;
    rd_chk(32'h3000_0014, 32'h0, "R1 rows cleared by reset");
    fan_chk(8'd255, "R1 fanout after reset");
  endtask

  initial begin
    cyc = 0; stb = 0; we = 0; sel = 0; adr = 0; wdat = 0; avld = 0; aidx = 0;
    t_reset();
    t_decode();
    t_word_rw();
    t_byte_lanes();
    t_hole();
    t_other_regions();
    t_ack_timing();
    t_fanout();
    t_stream();
    t_reset_midrun();
    finish_run();
  end
endmodule